// File: doc/BRIEF.md
# Page-Mode DRAM Strobe Controller

This block sits between a synchronous request port and an asynchronous 512K x 16 page-mode DRAM. Each request carries a 19-bit word address, a write flag, two byte-enable bits and 16 bits of write data. The controller splits the address into a row and a column. It then sequences the active-low row strobe, two byte-lane column strobes, write enable and output enable, together with the multiplexed address bus and the direction of the data bus.

After a row is opened it stays open. A later request to the same row costs only a column cycle. A request to a different row, or a refresh request, first closes the row. The row strobe must have been low for its minimum time before it rises, and it then stays high for the precharge time. A refresh request is answered with a grant that lasts while the requester holds its request; during the grant the row is closed and precharged.

Every timing minimum is a parameter counted in system clocks. Writes use early-write timing, so the memory never drives its data pins against the controller.

Top module: `fpdram_ctrl`

## Requirements
- R1: The word address splits into row = address bits [18:9], put on `dram_addr` when the row strobe falls, and column = address bits [8:0], zero-extended on `dram_addr` when a column strobe falls.
- R2: Byte enable bit 0 selects the lower lane, driven by `dram_cas_n[0]`. Bit 1 selects the upper lane, driven by `dram_cas_n[1]`. A column cycle lowers exactly the strobes whose enable bit is 1, and lowers them together.
- R3: `dram_ras_n` stays low for at least T_RAS_CYC cycles once it falls. It stays high for at least T_RP_CYC cycles between activations.
- R4: Each column strobe falls at least T_RCD_CYC cycles after the row strobe falls. The row address is held for T_RAH_CYC cycles after the row strobe falls. The column address stays unchanged while any column strobe is low, and no column strobe is low while the row strobe is high.
- R5: A column strobe stays low for at least T_CAS_CYC cycles, and for at least T_CAA_CYC cycles on a read. Within a page, the column strobes stay high for at least T_CP_CYC cycles between column cycles.
- R6: A write lowers `dram_we_n` and drives `dram_dq_oe` at least one cycle before the column strobes fall, with `dram_oe_n` high. `dram_dq_oe` is high only during writes.
- R7: A read holds `dram_we_n` high and `dram_oe_n` low. It samples `dram_dq_in` on the last cycle of the column strobe, at least T_RAC_CYC cycles after the row strobe fell. It returns the data with a one-cycle `rsp_valid` pulse; lanes that are not enabled read as zero.
- R8: A request to the open row is served with no new fall of the row strobe.
- R9: A request to another row, or a refresh request, raises the row strobe. The next activation, or the grant `ref_ack`, comes only after precharge. `ref_ack` holds the row strobe high and lasts until `ref_req` drops. While `ref_req` is high, `req_ready` is low.
- R10: After reset all strobes and `dram_we_n`/`dram_oe_n` are high, `dram_dq_oe` and `rsp_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | 19 | Word address, row in the upper bits |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 1 upper lane |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| ref_req | input | 1 | Refresh slot request |
| ref_ack | output | 1 | Refresh slot granted, row closed |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Column strobes per lane, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data to the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data from the memory |

## Verification
A wrong sequencer state shows at the strobes within a cycle or two. Such a state can be a shortened counter, a missed transition to precharge, or a write flag latched late. It appears as a low or high pulse shorter than its minimum, as a column strobe without the row strobe, as a second row activation on a page hit, or as write enable falling together with the column strobe. A byte-lane or address-mux fault shows one column cycle later: the memory model latches the wrong row, column or lane. A sampling fault shows on the next read response as the junk value that the model drives before the access time has elapsed.

// File: rtl/fpdram_pkg.sv
package fpdram_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_ACT, ST_CSET, ST_COL, ST_CPRE, ST_OPEN, ST_PRE, ST_REF
   } fp_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/fpdram_timer.sv
module fpdram_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/fpdram_age.sv
module fpdram_age #(
   parameter int LIMIT = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic reached
);
   localparam int W = $clog2(LIMIT + 1);
   logic [W-1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    age_q <= '0;
      else if (!run)                 age_q <= '0;
      else if (age_q != W'(LIMIT))   age_q <= age_q + 1'b1;
   end

   // rising edge on the next clock gives a low time of age_q + 1 cycles
   assign reached = (32'(age_q) + 1 >= LIMIT);
endmodule

// File: rtl/fpdram_lane.sv
module fpdram_lane (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cas_on,
   input  logic       lane_en,
   input  logic       capture,
   input  logic [7:0] dq_byte,
   output logic       cas_n,
   output logic [7:0] rd_byte
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cas_n   <= 1'b1;
         rd_byte <= '0;
      end else begin
         cas_n <= !(cas_on && lane_en);
         if (capture) rd_byte <= lane_en ? dq_byte : 8'h00;
      end
   end
endmodule

// File: rtl/fpdram_ctrl.sv
module fpdram_ctrl
   import fpdram_pkg::*;
#(
   parameter int ADDR_W    = 19,
   parameter int ROW_W     = 10,
   parameter int DATA_W    = 16,
   parameter int T_RAS_CYC = 12,
   parameter int T_RP_CYC  = 8,
   parameter int T_RCD_CYC = 6,
   parameter int T_RAH_CYC = 2,
   parameter int T_CAS_CYC = 3,
   parameter int T_CAH_CYC = 2,
   parameter int T_CP_CYC  = 2,
   parameter int T_CAA_CYC = 6,
   parameter int T_RAC_CYC = 12,
   localparam int COL_W  = ADDR_W - ROW_W,
   localparam int LANES  = DATA_W / 8,
   localparam int AMUX_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [LANES-1:0]  req_be,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   input  logic              ref_req,
   output logic              ref_ack,
   output logic              dram_ras_n,
   output logic [LANES-1:0]  dram_cas_n,
   output logic              dram_we_n,
   output logic              dram_oe_n,
   output logic [AMUX_W-1:0] dram_addr,
   output logic [DATA_W-1:0] dram_dq_out,
   output logic              dram_dq_oe,
   input  logic [DATA_W-1:0] dram_dq_in
);
   localparam int T_RD_CYC = imax(T_CAS_CYC, T_CAA_CYC);
   localparam int T_MAX    = imax(imax(T_RP_CYC, T_RD_CYC), imax(T_CP_CYC, T_RCD_CYC));
   localparam int CNT_W    = $clog2(T_MAX + 1);

   initial begin
      assert (DATA_W % 8 == 0) else $error("DATA_W must be whole bytes");
      assert (T_RCD_CYC >= 2) else $error("T_RCD_CYC below 2");
      assert (T_RCD_CYC - 1 >= T_RAH_CYC) else $error("row hold not met");
      assert (T_CAS_CYC >= T_CAH_CYC) else $error("column hold not met");
      assert (T_RCD_CYC + T_RD_CYC >= T_RAC_CYC) else $error("row access not met");
      assert (T_CP_CYC >= 1 && T_RP_CYC >= 1) else $error("precharge below 1");
   end

   fp_state_e state, nxt;
   logic [ROW_W-1:0]  req_row, row_q;
   logic [COL_W-1:0]  req_col, col_q;
   logic [LANES-1:0]  be_q;
   logic              wr_q, accept, hit, op_wr, t_ld, t_done, age_ok, capture, in_col;
   logic [CNT_W-1:0]  t_val;
   logic              ras_n_q, we_n_q, oe_n_q, dq_oe_q, rsp_q;
   logic [AMUX_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   assign req_row = req_addr[ADDR_W-1 -: ROW_W];
   assign req_col = req_addr[COL_W-1:0];
   assign hit     = (req_row == row_q);

   always_comb begin
      req_ready = !ref_req && ((state == ST_IDLE) || (state == ST_OPEN && hit));
      accept    = req_valid && req_ready;
      op_wr     = accept ? req_write : wr_q;
      nxt       = state;
      t_ld      = 1'b0;
      t_val     = '0;
      unique case (state)
         ST_IDLE: if (ref_req) nxt = ST_REF;
                  else if (accept) begin
                     nxt = ST_ACT; t_ld = 1'b1; t_val = CNT_W'(T_RCD_CYC - 2);
                  end
         ST_ACT:  if (t_done) nxt = ST_CSET;
         ST_CSET: begin
                     nxt = ST_COL; t_ld = 1'b1;
                     t_val = wr_q ? CNT_W'(T_CAS_CYC - 1) : CNT_W'(T_RD_CYC - 1);
                  end
         ST_COL:  if (t_done) begin
                     nxt = ST_CPRE; t_ld = 1'b1; t_val = CNT_W'(T_CP_CYC - 1);
                  end
         ST_CPRE: if (t_done) nxt = ST_OPEN;
         ST_OPEN: if (accept) nxt = ST_CSET;
                  else if ((ref_req || req_valid) && age_ok) begin
                     nxt = ST_PRE; t_ld = 1'b1; t_val = CNT_W'(T_RP_CYC - 1);
                  end
         ST_PRE:  if (t_done) nxt = ST_IDLE;
         ST_REF:  if (!ref_req) nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   assign in_col  = (nxt == ST_CSET) || (nxt == ST_COL);
   assign capture = (state == ST_COL) && t_done && !wr_q;

   fpdram_timer #(.W(CNT_W)) timer_i (
      .clk(clk), .rst_n(rst_n), .load(t_ld), .load_val(t_val), .done(t_done));

   fpdram_age #(.LIMIT(T_RAS_CYC)) age_i (
      .clk(clk), .rst_n(rst_n), .run(!ras_n_q), .reached(age_ok));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         row_q   <= '0;  col_q <= '0;  be_q <= '0;  wr_q <= 1'b0;
         wdata_q <= '0;  addr_q <= '0;
         ras_n_q <= 1'b1; we_n_q <= 1'b1; oe_n_q <= 1'b1;
         dq_oe_q <= 1'b0; rsp_q <= 1'b0;
      end else begin
         state <= nxt;
         if (accept) begin
            wr_q    <= req_write;
            be_q    <= req_be;
            wdata_q <= req_wdata;
            col_q   <= req_col;
            if (state == ST_IDLE) row_q <= req_row;
         end
         ras_n_q <= !(nxt inside {ST_ACT, ST_CSET, ST_COL, ST_CPRE, ST_OPEN});
         we_n_q  <= !(in_col && op_wr);
         oe_n_q  <= !(in_col && !op_wr);
         dq_oe_q <= in_col && op_wr;
         rsp_q   <= capture;
         if (accept && state == ST_IDLE) addr_q <= AMUX_W'(req_row);
         else if (nxt == ST_CSET)         addr_q <= AMUX_W'(accept ? req_col : col_q);
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      fpdram_lane lane_i (
         .clk(clk), .rst_n(rst_n), .cas_on(nxt == ST_COL), .lane_en(be_q[i]),
         .capture(capture), .dq_byte(dram_dq_in[8*i +: 8]),
         .cas_n(dram_cas_n[i]), .rd_byte(rsp_rdata[8*i +: 8]));
   end

   assign ref_ack     = (state == ST_REF);
   assign rsp_valid   = rsp_q;
   assign dram_ras_n  = ras_n_q;
   assign dram_we_n   = we_n_q;
   assign dram_oe_n   = oe_n_q;
   assign dram_addr   = addr_q;
   assign dram_dq_out = wdata_q;
   assign dram_dq_oe  = dq_oe_q;
endmodule

// File: rtl/fpdram_ctrl_chk.sv
module fpdram_ctrl_chk #(
   parameter int LANES     = 2,
   parameter int AMUX_W    = 10,
   parameter int T_RAS_CYC = 12,
   parameter int T_RP_CYC  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              ref_req,
   input logic              ref_ack,
   input logic              dram_ras_n,
   input logic [LANES-1:0]  dram_cas_n,
   input logic              dram_we_n,
   input logic              dram_oe_n,
   input logic [AMUX_W-1:0] dram_addr,
   input logic              dram_dq_oe
);
   logic [7:0] lo_cnt, hi_cnt;
   logic       seen_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_cnt <= '0; hi_cnt <= 8'hff; seen_low <= 1'b0;
      end else begin
         lo_cnt <= dram_ras_n ? 8'd0 : ((lo_cnt == 8'hff) ? lo_cnt : lo_cnt + 1'b1);
         hi_cnt <= !dram_ras_n ? 8'd0 : ((hi_cnt == 8'hff) ? hi_cnt : hi_cnt + 1'b1);
         if (!dram_ras_n) seen_low <= 1'b1;
      end
   end

   AST_RAS_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_low && $rose(dram_ras_n)) |-> (32'(lo_cnt) >= T_RAS_CYC));           // R3
   AST_RAS_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_low && $fell(dram_ras_n)) |-> (32'(hi_cnt) >= T_RP_CYC));            // R3
   AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      !(&dram_cas_n) |-> !dram_ras_n);                                            // R4
   AST_COL_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&dram_cas_n) && !(&$past(dram_cas_n))) |-> $stable(dram_addr));          // R4
   AST_EARLY_WE: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_we_n && !(&dram_cas_n) && (&$past(dram_cas_n))) |-> (!$past(dram_we_n) && $past(dram_dq_oe))); // R6
   AST_DQ_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      dram_dq_oe |-> (!dram_we_n && dram_oe_n));                                  // R6
   AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_oe_n |-> dram_we_n);                                                  // R7
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);                                                  // R7
   AST_REF_ROW_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      ref_ack |-> (dram_ras_n && (&dram_cas_n)));                                 // R9
   AST_REF_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req |-> !req_ready);                                                    // R9
endmodule

bind fpdram_ctrl fpdram_ctrl_chk #(
   .LANES(LANES), .AMUX_W(AMUX_W), .T_RAS_CYC(T_RAS_CYC), .T_RP_CYC(T_RP_CYC)
) chk_i (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
   .ref_req(ref_req), .ref_ack(ref_ack), .dram_ras_n(dram_ras_n),
   .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
   .dram_addr(dram_addr), .dram_dq_oe(dram_dq_oe));

// File: tb/fpdram_ctrl_tb_top.sv
`timescale 1ns/1ps
module fpdram_ctrl_tb_top;
   localparam int T_RAS = 12, T_RP = 8, T_RCD = 6, T_RAH = 2, T_CAS = 3;
   localparam int T_CP = 2, T_CAA = 6, T_RAC = 12;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_write = 0, ref_req = 0;
   logic [18:0] req_addr = '0;
   logic [1:0]  req_be = '0;
   logic [15:0] req_wdata = '0, dram_dq_in = 16'hDEAD;
   logic req_ready, rsp_valid, ref_ack, dram_ras_n, dram_we_n, dram_oe_n, dram_dq_oe;
   logic [15:0] rsp_rdata, dram_dq_out;
   logic [1:0]  dram_cas_n;
   logic [9:0]  dram_addr;

   always #2.5 clk = ~clk;

   fpdram_ctrl dut_i (.*);

   int n_chk = 0, n_fail = 0, cyc = 0;
   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- memory model on the strobe pins ----------------
   logic [15:0] mem  [int];
   logic [15:0] gold [int];
   int ras_lo = 0, ras_hi = 100, cas_lo = 0, cas_hi = 0, ras_falls = 0, col_done = 0;
   bit prev_ras = 1, prev_any = 0, prev_we = 1, cas_hi_ok = 0;
   logic [9:0] cur_row = '0; logic [8:0] cur_col = '0; logic [1:0] last_lanes = 2'b11;

   always @(negedge clk) begin
      bit any_low;
      int key;
      logic [15:0] rd;
      cyc++;
      any_low = !(&dram_cas_n);
      if (prev_ras && !dram_ras_n) begin
         chk(ras_hi >= T_RP, "R3", "ras high time", ras_hi, T_RP);
         ras_falls++; cur_row = dram_addr; ras_lo = 0; cas_hi_ok = 0;
      end
      if (!prev_ras && dram_ras_n) chk(ras_lo >= T_RAS, "R3", "ras low time", ras_lo, T_RAS);
      if (!dram_ras_n && ras_lo < T_RAH) chk(dram_addr == cur_row, "R4", "row hold", dram_addr, cur_row);
      if (!prev_any && any_low) begin
         chk(!dram_ras_n && ras_lo >= T_RCD, "R4", "ras to cas", ras_lo, T_RCD);
         if (cas_hi_ok) chk(cas_hi >= T_CP, "R5", "cas high time", cas_hi, T_CP);
         cur_col = dram_addr[8:0]; last_lanes = dram_cas_n; cas_lo = 0;
         key = {cur_row, cur_col};
         if (!dram_we_n) begin
            chk(!prev_we && dram_dq_oe && dram_oe_n, "R6", "early write", {prev_we, dram_dq_oe, dram_oe_n}, 3'b011);
            if (!mem.exists(key)) mem[key] = 16'h0;
            if (!dram_cas_n[0]) mem[key][7:0]  = dram_dq_out[7:0];
            if (!dram_cas_n[1]) mem[key][15:8] = dram_dq_out[15:8];
         end else
            chk(!dram_dq_oe && !dram_oe_n, "R7", "read pins", {dram_dq_oe, dram_oe_n}, 0);
      end else if (prev_any && any_low)
         chk(dram_addr[8:0] == cur_col, "R4", "column hold", dram_addr, cur_col);
      if (prev_any && !any_low) begin
         chk(cas_lo >= (prev_we ? T_CAA : T_CAS), "R5", "cas low time", cas_lo, prev_we ? T_CAA : T_CAS);
         col_done++; cas_hi = 0; cas_hi_ok = 1;
      end
      key = {cur_row, cur_col};
      rd = mem.exists(key) ? mem[key] : 16'h0;
      if (any_low && !dram_oe_n && dram_we_n && cas_lo + 1 >= T_CAA && ras_lo + 1 >= T_RAC)
         dram_dq_in = {dram_cas_n[1] ? 8'hDE : rd[15:8], dram_cas_n[0] ? 8'hAD : rd[7:0]};
      else
         dram_dq_in = 16'hDEAD;
      if (!dram_ras_n) begin ras_lo++; ras_hi = 0; end else ras_hi++;
      if (any_low) cas_lo++; else cas_hi++;
      prev_ras = dram_ras_n; prev_any = any_low; prev_we = dram_we_n;
   end

   // ---------------- scoreboard ----------------
   logic [15:0] exp_q[$];
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) chk(0, "R7", "unexpected response", rsp_rdata, 0);
         else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk(rsp_rdata == e, "R7", "read data", rsp_rdata, e);
         end
      end
   end

   task automatic do_req(input logic [18:0] a, input bit wr, input logic [1:0] be, input logic [15:0] d);
      int c0, g, tmo;
      logic [15:0] gv;
      req_addr = a; req_write = wr; req_be = be; req_wdata = d; req_valid = 1;
      forever begin #1; if (req_ready) break; @(negedge clk); end
      c0 = col_done;
      @(posedge clk); #1 req_valid = 0;
      g = int'(a); gv = gold.exists(g) ? gold[g] : 16'h0;
      if (wr) begin
         if (be[0]) gv[7:0]  = d[7:0];
         if (be[1]) gv[15:8] = d[15:8];
         gold[g] = gv;
      end else
         exp_q.push_back({be[1] ? gv[15:8] : 8'h0, be[0] ? gv[7:0] : 8'h0});
      tmo = 0;
      while (col_done == c0 && tmo < 200) begin @(negedge clk); #1; tmo++; end
      chk(cur_row == a[18:9], "R1", "row field", cur_row, a[18:9]);
      chk(cur_col == a[8:0],  "R1", "column field", cur_col, a[8:0]);
      chk(last_lanes == ~be,  "R2", "lane strobes", last_lanes, ~be);
   endtask

   initial begin : watchdog
      wait (cyc > 60000);
      chk(0, "WD", "watchdog expired", cyc, 60000);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      int f0, tmo;
      repeat (10) @(negedge clk);
      #1;
      chk({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe, rsp_valid} == 7'b1111100,
          "R10", "reset pins", {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe, rsp_valid}, 7'b1111100);
      rst_n = 1;
      @(negedge clk); #1;
      chk(req_ready == 1, "R10", "ready after reset", req_ready, 1);

      // page hits on row 5
      f0 = ras_falls;
      do_req({10'd5, 9'd3}, 1, 2'b11, 16'hA55A);
      do_req({10'd5, 9'd3}, 0, 2'b11, 16'h0);
      do_req({10'd5, 9'd4}, 1, 2'b11, 16'h1357);
      do_req({10'd5, 9'd4}, 0, 2'b11, 16'h0);
      chk(ras_falls - f0 == 1, "R8", "row activations on page hits", ras_falls - f0, 1);

      // byte lanes
      do_req({10'd5, 9'd3}, 1, 2'b10, 16'h12FF);
      do_req({10'd5, 9'd3}, 0, 2'b11, 16'h0);
      do_req({10'd5, 9'd3}, 1, 2'b01, 16'hFF34);
      do_req({10'd5, 9'd3}, 0, 2'b01, 16'h0);
      do_req({10'd5, 9'd3}, 0, 2'b10, 16'h0);

      // row miss closes and reopens
      f0 = ras_falls;
      do_req({10'd7, 9'd3}, 1, 2'b11, 16'hBEEF);
      do_req({10'd5, 9'd3}, 0, 2'b11, 16'h0);
      do_req({10'd7, 9'd3}, 0, 2'b11, 16'h0);
      chk(ras_falls - f0 == 3, "R9", "activations on row misses", ras_falls - f0, 3);

      // extremes of the address
      do_req(19'h7FFFF, 1, 2'b11, 16'hC3C3);
      do_req(19'h00000, 1, 2'b11, 16'h3C3C);
      do_req(19'h7FFFF, 0, 2'b11, 16'h0);
      do_req(19'h00000, 0, 2'b11, 16'h0);

      // mixed pattern across three rows
      for (int i = 0; i < 12; i++)
         do_req({10'(i % 3 + 20), 9'(i * 37)}, 1, 2'(i % 3 + 1), 16'(i * 16'h1111 ^ 16'h5A00));
      for (int i = 0; i < 12; i++)
         do_req({10'(i % 3 + 20), 9'(i * 37)}, 0, 2'b11, 16'h0);

      // refresh while a row is open
      @(negedge clk); #1;
      ref_req = 1; req_valid = 1; req_addr = {10'd22, 9'd0}; req_write = 0; req_be = 2'b11;
      tmo = 0;
      while (!ref_ack && tmo < 100) begin
         #1; chk(!req_ready, "R9", "ready during refresh request", req_ready, 0);
         @(negedge clk); #1; tmo++;
      end
      chk(ref_ack && dram_ras_n && ras_hi >= T_RP, "R9", "grant after precharge", {ref_ack, dram_ras_n}, 2'b11);
      req_valid = 0;
      repeat (5) @(negedge clk);
      #1;
      chk(ref_ack && dram_ras_n, "R9", "grant held", {ref_ack, dram_ras_n}, 2'b11);
      ref_req = 0;
      @(negedge clk); #1;
      chk(!ref_ack, "R9", "grant released", ref_ack, 0);
      f0 = ras_falls;
      do_req({10'd5, 9'd3}, 0, 2'b11, 16'h0);
      chk(ras_falls - f0 == 1, "R9", "reopen after refresh", ras_falls - f0, 1);

      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "R7", "responses outstanding", exp_q.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule